// File: doc/BRIEF.md
# Rename and Issue Stage with Issue-Time Elimination

This block sits between a uop queue and the out-of-order back end. Each cycle it looks at up to four uops at the front of the queue. It reports how many of them it takes, and it allocates them in program order into a circular reorder buffer. Uops that need execution also get a reservation-station slot and a fresh rename mapping. No-ops, register-zeroing idioms and register-to-register moves are resolved at issue. They take a reorder-buffer slot that is already complete, never reach the scheduler, and act only on the rename map. A zeroing idiom points its destination at a constant-zero tag. A move copies the source's current mapping.

A group only issues when both the reorder buffer and the reservation station could accept a full group of four. This rule holds even when the queue offers fewer uops. Execution is modelled by a completion port that names a reorder-buffer index. Retirement drains up to four completed entries per cycle from the head, in order. Any mapping that still points at a retired entry falls back to the architectural value. A lookup port shows the mapping of any architectural register. The reorder-buffer depth must be a power of two.

Top module: `issue_rename_stage`

## Requirements
- R1: `issue_cnt` equals min(`in_count`, 4) whenever resources allow, so partial groups issue; it never exceeds `in_count` or 4.
- R2: `issue_cnt` is 0 unless the reorder buffer has at least 4 free entries and the reservation station has at least 4 free entries, regardless of how many uops are offered.
- R3: An ALU uop (kind 0) takes a not-complete reorder-buffer entry and one reservation-station entry, and maps its destination to tag {2'b01, rob index}.
- R4: A fused compare-and-branch uop (kind 1) occupies one issue slot, one reorder-buffer entry (not complete) and one reservation-station entry, and leaves the rename map unchanged.
- R5: A NOP (kind 2) takes a complete reorder-buffer entry, no reservation-station entry, and leaves the map unchanged.
- R6: A zeroing idiom (kind 3) takes a complete reorder-buffer entry and no reservation-station entry, and maps its destination to tag {2'b10, 0}.
- R7: A move (kind 4) takes a complete reorder-buffer entry and no reservation-station entry, and gives its destination the source's mapping, including renames made by earlier slots of the same group.
- R8: A completion naming an occupied, not-yet-complete reorder-buffer index marks it complete and frees its reservation-station entry. A completion naming any other index changes nothing.
- R9: `retire_cnt` counts the run of complete entries at the head, up to 4, and those entries leave the reorder buffer at the next clock edge.
- R10: When an entry retires, every mapping that names it reverts to the architectural tag 0.
- R11: After reset the reorder buffer and the reservation station are empty and every register maps to tag 0.

Uop slot i sits at `in_uops[9*i +: 9]` as {kind[2:0], dst[2:0], src[2:0]}. The tag mode is in bits [5:4] and the index is in bits [3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_count | input | 3 | Uops valid at the queue front (0..4) |
| in_uops | input | 36 | Four packed uop slots, oldest in slot 0 |
| issue_cnt | output | 3 | Uops taken this cycle |
| cmpl_valid | input | 1 | Execution completion strobe |
| cmpl_idx | input | 4 | Reorder-buffer index that completed |
| retire_cnt | output | 3 | Entries retiring at the next edge |
| rob_count | output | 5 | Occupied reorder-buffer entries |
| rs_count | output | 4 | Occupied reservation-station entries |
| lk_reg | input | 3 | Architectural register to look up |
| lk_tag | output | 6 | Current mapping of `lk_reg` |

## Verification
The assertions check three things on every cycle. Allocation never happens unless both structures have room for a full group. The reservation station never holds more entries than the reorder buffer. Every accepted completion leaves its entry complete, and every requested scheduler entry gets placed. The bench compares each output against a behavioural model on every cycle. That model is what shows the effects that play out over many cycles: partial groups, chained moves inside one group, in-order retirement stopping at an incomplete entry, stale mappings reverting at retirement, and ignored completions.

// File: rtl/issue_pkg.sv
// Shared definitions for the rename/issue stage.
// Assumes uop kinds fit in three bits and tag modes in two.
package issue_pkg;
    typedef enum logic [2:0] {
        K_ALU    = 3'd0,
        K_BRANCH = 3'd1,
        K_NOP    = 3'd2,
        K_ZERO   = 3'd3,
        K_MOVE   = 3'd4
    } uop_kind_e;

    localparam logic [1:0] TM_ARCH = 2'b00;
    localparam logic [1:0] TM_ROB  = 2'b01;
    localparam logic [1:0] TM_ZERO = 2'b10;

    // True for kinds resolved entirely at issue
    function automatic logic kind_elim(input logic [2:0] k);
        return (k == K_NOP) || (k == K_ZERO) || (k == K_MOVE);
    endfunction
endpackage

// File: rtl/issue_rob.sv
// Circular reorder buffer: allocates up to ISSUE_W entries at the tail,
// accepts one completion per cycle, retires the complete run at the head.
// Assumes DEPTH is a power of two and the caller only allocates with room.
module issue_rob #(
    parameter int ISSUE_W = 4,
    parameter int DEPTH   = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [$clog2(ISSUE_W+1)-1:0]  alloc_n,
    input  logic [ISSUE_W-1:0]            alloc_elim,
    input  logic                          cmpl_valid,
    input  logic [$clog2(DEPTH)-1:0]      cmpl_idx,
    output logic [$clog2(DEPTH)-1:0]      tail,
    output logic [$clog2(DEPTH)-1:0]      head,
    output logic [$clog2(DEPTH+1)-1:0]    count,
    output logic [$clog2(ISSUE_W+1)-1:0]  retire_n
);
    localparam int NW = $clog2(ISSUE_W+1);
    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] ROOM_LIMIT = CW'(DEPTH - ISSUE_W);

    logic [DEPTH-1:0] valid_q;
    logic [DEPTH-1:0] done_q;
    logic [IW-1:0]    head_q;
    logic [IW-1:0]    tail_q;
    logic [CW-1:0]    count_q;

    assign tail  = tail_q;
    assign head  = head_q;
    assign count = count_q;

    // Count the run of complete entries starting at the head
    always_comb begin
        logic stop;
        stop     = 1'b0;
        retire_n = '0;
        for (int k = 0; k < ISSUE_W; k++) begin
            if (!stop && (CW'(k) < count_q) && done_q[head_q + IW'(k)])
                retire_n = retire_n + NW'(1);
            else
                stop = 1'b1;
        end
    end

    // Update entry state and pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            done_q  <= '0;
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            for (int k = 0; k < ISSUE_W; k++)
                if (NW'(k) < retire_n)
                    valid_q[head_q + IW'(k)] <= 1'b0;
            if (cmpl_valid && valid_q[cmpl_idx] && !done_q[cmpl_idx])
                done_q[cmpl_idx] <= 1'b1;
            for (int k = 0; k < ISSUE_W; k++)
                if (NW'(k) < alloc_n) begin
                    valid_q[tail_q + IW'(k)] <= 1'b1;
                    done_q[tail_q + IW'(k)]  <= alloc_elim[k];
                end
            head_q  <= head_q + IW'(retire_n);
            tail_q  <= tail_q + IW'(alloc_n);
            count_q <= count_q + CW'(alloc_n) - CW'(retire_n);
        end
    end

    // R2: allocation only happens with room for a full group
    p_rob_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_n != '0) |-> (count_q <= ROOM_LIMIT));

    // R8: an accepted completion leaves its entry complete
    p_cmpl_marks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_valid && valid_q[cmpl_idx] && !done_q[cmpl_idx]) |=> done_q[$past(cmpl_idx)]);

    // R9: occupancy never exceeds the depth
    p_rob_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));
endmodule

// File: rtl/issue_rs_pool.sv
// Reservation-station occupancy pool: places each requesting slot into the
// lowest free entry and frees the entry whose stored reorder index completes.
// Assumes the caller only requests when at least ISSUE_W entries are free.
module issue_rs_pool #(
    parameter int ISSUE_W   = 4,
    parameter int DEPTH     = 8,
    parameter int ROB_DEPTH = 16
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [ISSUE_W-1:0]                      req_vld,
    input  logic [ISSUE_W-1:0][$clog2(ROB_DEPTH)-1:0] req_idx,
    input  logic                                    cmpl_valid,
    input  logic [$clog2(ROB_DEPTH)-1:0]            cmpl_idx,
    output logic [$clog2(DEPTH+1)-1:0]              occ
);
    localparam int IW = $clog2(ROB_DEPTH);
    localparam int OW = $clog2(DEPTH+1);
    localparam logic [OW-1:0] ROOM_LIMIT = OW'(DEPTH - ISSUE_W);

    logic [DEPTH-1:0] v_q;
    logic [DEPTH-1:0] v_d;
    logic [IW-1:0]    t_q [DEPTH];
    logic [IW-1:0]    t_d [DEPTH];

    // Free on completion match, then place new requests in free entries
    always_comb begin
        logic [DEPTH-1:0] taken;
        logic             placed;
        v_d   = v_q;
        t_d   = t_q;
        taken = '0;
        for (int e = 0; e < DEPTH; e++)
            if (cmpl_valid && v_q[e] && (t_q[e] == cmpl_idx))
                v_d[e] = 1'b0;
        for (int s = 0; s < ISSUE_W; s++) begin
            placed = 1'b0;
            if (req_vld[s]) begin
                for (int e = 0; e < DEPTH; e++) begin
                    if (!placed && !v_q[e] && !taken[e]) begin
                        taken[e] = 1'b1;
                        v_d[e]   = 1'b1;
                        t_d[e]   = req_idx[s];
                        placed   = 1'b1;
                    end
                end
            end
        end
    end

    // Register pool state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
            for (int e = 0; e < DEPTH; e++) t_q[e] <= '0;
        end else begin
            v_q <= v_d;
            t_q <= t_d;
        end
    end

    // Population count of occupied entries
    always_comb begin
        occ = '0;
        for (int e = 0; e < DEPTH; e++)
            occ = occ + OW'(v_q[e]);
    end

    // R2: requests only arrive with room for a full group
    p_rs_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld != '0) |-> (occ <= ROOM_LIMIT));

    // R3: every requesting slot is placed into a new entry
    p_rs_place_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld != '0) |-> ($countones(v_d & ~v_q) == $countones(req_vld)));
endmodule

// File: rtl/issue_rename_map.sv
// Architectural-to-tag rename map. It first clears mappings that name
// retiring entries, then applies the issue group slot by slot so that later
// slots see earlier renames. It also provides a combinational lookup port.
// Assumes ROB_DEPTH is a power of two.
module issue_rename_map import issue_pkg::*; #(
    parameter int ISSUE_W   = 4,
    parameter int ROB_DEPTH = 16,
    parameter int ARCH_REGS = 8
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic [$clog2(ROB_DEPTH)-1:0]              retire_head,
    input  logic [$clog2(ISSUE_W+1)-1:0]              retire_n,
    input  logic [ISSUE_W-1:0]                        slot_vld,
    input  logic [ISSUE_W-1:0][2:0]                   slot_kind,
    input  logic [ISSUE_W-1:0][$clog2(ARCH_REGS)-1:0] slot_dst,
    input  logic [ISSUE_W-1:0][$clog2(ARCH_REGS)-1:0] slot_src,
    input  logic [ISSUE_W-1:0][$clog2(ROB_DEPTH)-1:0] slot_idx,
    input  logic [$clog2(ARCH_REGS)-1:0]              lk_reg,
    output logic [$clog2(ROB_DEPTH)+1:0]              lk_tag
);
    localparam int NW = $clog2(ISSUE_W+1);
    localparam int IW = $clog2(ROB_DEPTH);
    localparam int TW = IW + 2;

    logic [TW-1:0] map_q [ARCH_REGS];
    logic [TW-1:0] map_d [ARCH_REGS];
    logic [ROB_DEPTH-1:0] retiring;

    // Flag reorder entries that leave at this edge
    always_comb begin
        retiring = '0;
        for (int k = 0; k < ISSUE_W; k++)
            if (NW'(k) < retire_n)
                retiring[retire_head + IW'(k)] = 1'b1;
    end

    // Next map: revert retired tags, then apply slots in order
    always_comb begin
        map_d = map_q;
        for (int r = 0; r < ARCH_REGS; r++)
            if ((map_q[r][TW-1:TW-2] == TM_ROB) && retiring[map_q[r][IW-1:0]])
                map_d[r] = {TM_ARCH, {IW{1'b0}}};
        for (int i = 0; i < ISSUE_W; i++) begin
            if (slot_vld[i]) begin
                case (slot_kind[i])
                    K_ALU:   map_d[slot_dst[i]] = {TM_ROB, slot_idx[i]};
                    K_ZERO:  map_d[slot_dst[i]] = {TM_ZERO, {IW{1'b0}}};
                    K_MOVE:  map_d[slot_dst[i]] = map_d[slot_src[i]];
                    default: ;
                endcase
            end
        end
    end

    // Register the map
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ARCH_REGS; r++) map_q[r] <= '0;
        end else begin
            map_q <= map_d;
        end
    end

    // Lookup port
    assign lk_tag = map_q[lk_reg];

    // R3: a lone ALU uop maps its destination to its reorder entry
    p_alu_maps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_vld[0] && !slot_vld[1] && (slot_kind[0] == K_ALU))
        |=> (map_q[$past(slot_dst[0])] == {TM_ROB, $past(slot_idx[0])}));
endmodule

// File: rtl/issue_rename_stage.sv
// Top of the rename/issue stage. It gates whole groups on full-group room
// in both the reorder buffer and the reservation station, splits eliminated
// uops away from the scheduler, and wires the map, buffer and pool together.
// Assumes in_count never exceeds ISSUE_W and ROB_DEPTH is a power of two.
module issue_rename_stage import issue_pkg::*; #(
    parameter int ISSUE_W   = 4,
    parameter int ROB_DEPTH = 16,
    parameter int RS_DEPTH  = 8,
    parameter int ARCH_REGS = 8
) (
    input  logic                                              clk,
    input  logic                                              rst_n,
    input  logic [$clog2(ISSUE_W+1)-1:0]                      in_count,
    input  logic [ISSUE_W*(3+2*$clog2(ARCH_REGS))-1:0]        in_uops,
    output logic [$clog2(ISSUE_W+1)-1:0]                      issue_cnt,
    input  logic                                              cmpl_valid,
    input  logic [$clog2(ROB_DEPTH)-1:0]                      cmpl_idx,
    output logic [$clog2(ISSUE_W+1)-1:0]                      retire_cnt,
    output logic [$clog2(ROB_DEPTH+1)-1:0]                    rob_count,
    output logic [$clog2(RS_DEPTH+1)-1:0]                     rs_count,
    input  logic [$clog2(ARCH_REGS)-1:0]                      lk_reg,
    output logic [$clog2(ROB_DEPTH)+1:0]                      lk_tag
);
    localparam int NW    = $clog2(ISSUE_W+1);
    localparam int IW    = $clog2(ROB_DEPTH);
    localparam int REG_W = $clog2(ARCH_REGS);
    localparam int UOP_W = 3 + 2*REG_W;
    localparam int CW    = $clog2(ROB_DEPTH+1);
    localparam int SW    = $clog2(RS_DEPTH+1);
    localparam logic [CW-1:0] ROB_LIMIT = CW'(ROB_DEPTH - ISSUE_W);
    localparam logic [SW-1:0] RS_LIMIT  = SW'(RS_DEPTH - ISSUE_W);

    logic [NW-1:0]                 avail;
    logic                          go;
    logic [ISSUE_W-1:0]            slot_vld;
    logic [ISSUE_W-1:0]            slot_elim;
    logic [ISSUE_W-1:0]            rs_req;
    logic [ISSUE_W-1:0][2:0]       slot_kind;
    logic [ISSUE_W-1:0][REG_W-1:0] slot_dst;
    logic [ISSUE_W-1:0][REG_W-1:0] slot_src;
    logic [ISSUE_W-1:0][IW-1:0]    slot_idx;
    logic [IW-1:0]                 rob_tail;
    logic [IW-1:0]                 rob_head;

    // Group gate: offered uops issue only with full-group room in both
    always_comb begin
        avail     = (in_count > NW'(ISSUE_W)) ? NW'(ISSUE_W) : in_count;
        go        = (rob_count <= ROB_LIMIT) && (rs_count <= RS_LIMIT);
        issue_cnt = go ? avail : '0;
    end

    // Per-slot field extraction and classification
    for (genvar g = 0; g < ISSUE_W; g++) begin : g_slot
        assign slot_kind[g] = in_uops[g*UOP_W + 2*REG_W +: 3];
        assign slot_dst[g]  = in_uops[g*UOP_W + REG_W +: REG_W];
        assign slot_src[g]  = in_uops[g*UOP_W +: REG_W];
        assign slot_vld[g]  = NW'(g) < issue_cnt;
        assign slot_elim[g] = kind_elim(slot_kind[g]);
        assign rs_req[g]    = slot_vld[g] && !slot_elim[g];
        assign slot_idx[g]  = rob_tail + IW'(g);
    end

    issue_rob #(.ISSUE_W(ISSUE_W), .DEPTH(ROB_DEPTH)) u_rob (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_n    (issue_cnt),
        .alloc_elim (slot_elim),
        .cmpl_valid (cmpl_valid),
        .cmpl_idx   (cmpl_idx),
        .tail       (rob_tail),
        .head       (rob_head),
        .count      (rob_count),
        .retire_n   (retire_cnt)
    );

    issue_rs_pool #(.ISSUE_W(ISSUE_W), .DEPTH(RS_DEPTH), .ROB_DEPTH(ROB_DEPTH)) u_rs (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_vld    (rs_req),
        .req_idx    (slot_idx),
        .cmpl_valid (cmpl_valid),
        .cmpl_idx   (cmpl_idx),
        .occ        (rs_count)
    );

    issue_rename_map #(.ISSUE_W(ISSUE_W), .ROB_DEPTH(ROB_DEPTH), .ARCH_REGS(ARCH_REGS)) u_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .retire_head (rob_head),
        .retire_n    (retire_cnt),
        .slot_vld    (slot_vld),
        .slot_kind   (slot_kind),
        .slot_dst    (slot_dst),
        .slot_src    (slot_src),
        .slot_idx    (slot_idx),
        .lk_reg      (lk_reg),
        .lk_tag      (lk_tag)
    );

    // R1: never take more than offered or more than the width
    p_issue_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_cnt <= in_count) && (issue_cnt <= NW'(ISSUE_W)));

    // R8: every scheduler entry belongs to a live reorder entry
    p_rs_within_rob_r8: assert property (@(posedge clk) disable iff (!rst_n)
        CW'(rs_count) <= rob_count);
endmodule

// File: tb/issue_rename_stage_tb.sv
`timescale 1ns/100ps
// Bench: behavioural reference model compared on every clock.
module issue_rename_stage_tb_top;
    localparam int NI = 4;
    localparam int RD = 16;
    localparam int SD = 8;
    localparam int NR = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  in_count;
    logic [35:0] in_uops;
    logic [2:0]  issue_cnt;
    logic        cmpl_valid;
    logic [3:0]  cmpl_idx;
    logic [2:0]  retire_cnt;
    logic [4:0]  rob_count;
    logic [3:0]  rs_count;
    logic [2:0]  lk_reg;
    logic [5:0]  lk_tag;

    always #5 clk = ~clk;

    issue_rename_stage dut_i (
        .clk(clk), .rst_n(rst_n), .in_count(in_count), .in_uops(in_uops),
        .issue_cnt(issue_cnt), .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx),
        .retire_cnt(retire_cnt), .rob_count(rob_count), .rs_count(rs_count),
        .lk_reg(lk_reg), .lk_tag(lk_tag)
    );

    int checks = 0;
    int fails  = 0;

    // Reference model state; tags encoded as mode*16+index
    int m_head, m_tail, m_cnt, m_rs;
    bit m_valid [RD];
    bit m_done  [RD];
    int m_map   [NR];
    int uk [NI];
    int ud [NI];
    int us [NI];
    int cnt_drv;
    bit cv_drv;
    int ci_drv;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_head = 0; m_tail = 0; m_cnt = 0; m_rs = 0;
        for (int e = 0; e < RD; e++) begin m_valid[e] = 0; m_done[e] = 0; end
        for (int r = 0; r < NR; r++) m_map[r] = 0;
    endtask

    function automatic int exp_issue();
        if ((RD - m_cnt >= NI) && (SD - m_rs >= NI))
            return (cnt_drv > NI) ? NI : cnt_drv;
        return 0;
    endfunction

    function automatic int exp_retire();
        int n = 0;
        for (int k = 0; k < NI; k++) begin
            if (k < m_cnt && m_done[(m_head + k) % RD]) n++;
            else break;
        end
        return n;
    endfunction

    // Drive inputs, compare outputs, then advance the model at the edge
    task automatic step();
        int ei, er;
        @(negedge clk);
        in_count = 3'(cnt_drv);
        for (int i = 0; i < NI; i++)
            in_uops[i*9 +: 9] = {3'(uk[i]), 3'(ud[i]), 3'(us[i])};
        cmpl_valid = cv_drv;
        cmpl_idx   = 4'(ci_drv);
        #1;
        ei = exp_issue();
        er = exp_retire();
        chk("R1 R2", "issue_cnt", int'(issue_cnt), ei);
        chk("R9", "retire_cnt", int'(retire_cnt), er);
        chk("R3 R5 R9", "rob_count", int'(rob_count), m_cnt);
        chk("R3 R8", "rs_count", int'(rs_count), m_rs);
        for (int r = 0; r < NR; r++) begin
            lk_reg = 3'(r);
            #0.2;
            chk("R4 R6 R7 R10", $sformatf("lk_tag[%0d]", r), int'(lk_tag), m_map[r]);
        end
        @(posedge clk);
        // retirement and stale-mapping reversion (R9, R10)
        for (int k = 0; k < er; k++) begin
            int idx = (m_head + k) % RD;
            m_valid[idx] = 0;
            for (int r = 0; r < NR; r++)
                if (m_map[r] == 16 + idx) m_map[r] = 0;
        end
        m_head = (m_head + er) % RD;
        m_cnt -= er;
        // completion, ignored unless pending (R8)
        if (cv_drv && m_valid[ci_drv] && !m_done[ci_drv]) begin
            m_done[ci_drv] = 1;
            m_rs--;
        end
        // issue slots in order (R3..R7)
        for (int i = 0; i < ei; i++) begin
            int idx = (m_tail + i) % RD;
            m_valid[idx] = 1;
            case (uk[i])
                0: begin m_done[idx] = 0; m_rs++; m_map[ud[i]] = 16 + idx; end
                1: begin m_done[idx] = 0; m_rs++; end
                2: m_done[idx] = 1;
                3: begin m_done[idx] = 1; m_map[ud[i]] = 32; end
                default: begin m_done[idx] = 1; m_map[ud[i]] = m_map[us[i]]; end
            endcase
        end
        m_tail = (m_tail + ei) % RD;
        m_cnt += ei;
    endtask

    task automatic rand_group(input int maxn);
        cnt_drv = $urandom_range(maxn, 0);
        for (int i = 0; i < NI; i++) begin
            int w = $urandom_range(9, 0);
            uk[i] = (w < 4) ? 0 : (w == 4) ? 1 : (w == 5) ? 2 : (w == 6) ? 3 : 4;
            ud[i] = $urandom_range(NR - 1, 0);
            us[i] = $urandom_range(NR - 1, 0);
        end
    endtask

    task automatic rand_cmpl(input int pct);
        int off;
        cv_drv = 0; ci_drv = 0;
        if ($urandom_range(99, 0) < pct) begin
            off = $urandom_range(RD - 1, 0);
            for (int e = 0; e < RD; e++) begin
                int idx = (off + e) % RD;
                if (!cv_drv && m_valid[idx] && !m_done[idx]) begin
                    cv_drv = 1; ci_drv = idx;
                end
            end
        end else if ($urandom_range(9, 0) == 0) begin
            cv_drv = 1; ci_drv = $urandom_range(RD - 1, 0);   // R8 possibly ignored
        end
    endtask

    task automatic set_slot(input int i, input int k, input int d, input int s);
        uk[i] = k; ud[i] = d; us[i] = s;
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_count = '0; in_uops = '0; cmpl_valid = 1'b0; cmpl_idx = '0; lk_reg = '0;
        model_reset();
        cnt_drv = 0; cv_drv = 0; ci_drv = 0;
        for (int i = 0; i < NI; i++) set_slot(i, 2, 0, 0);
        repeat (3) @(posedge clk);
        // R11: reset state
        @(negedge clk); #1;
        chk("R11", "rob_count", int'(rob_count), 0);
        chk("R11", "rs_count", int'(rs_count), 0);
        chk("R11", "retire_cnt", int'(retire_cnt), 0);
        for (int r = 0; r < NR; r++) begin
            lk_reg = 3'(r); #0.2;
            chk("R11", "lk_tag", int'(lk_tag), 0);
        end
        rst_n = 1'b1;

        // Directed: ALU, chained move, zero idiom, NOP (R3 R5 R6 R7)
        cnt_drv = 4;
        set_slot(0, 0, 1, 0); set_slot(1, 4, 2, 1); set_slot(2, 3, 3, 0); set_slot(3, 2, 0, 0);
        step();
        // Directed: branch, move of zero, ALU, move of fresh ALU (R4 R7)
        set_slot(0, 1, 0, 0); set_slot(1, 4, 4, 3); set_slot(2, 0, 1, 0); set_slot(3, 4, 5, 1);
        step();
        // Partial group of 3 then 1 (R1)
        cnt_drv = 3;
        set_slot(0, 2, 0, 0); set_slot(1, 3, 6, 0); set_slot(2, 4, 7, 2);
        step();
        cnt_drv = 1; set_slot(0, 0, 6, 0);
        step();
        // Fill without completions until stalls appear (R2)
        for (int c = 0; c < 12; c++) begin rand_group(4); cnt_drv = 4; cv_drv = 0; step(); end
        // Drain with completions, queue idle (R8 R9 R10)
        for (int c = 0; c < 40; c++) begin cnt_drv = 0; rand_cmpl(100); step(); end
        // Random mixes with varying completion pressure
        for (int c = 0; c < 3000; c++) begin
            rand_group(4);
            rand_cmpl((c / 500) % 2 == 0 ? 90 : 40);
            step();
        end
        for (int c = 0; c < 60; c++) begin cnt_drv = 0; rand_cmpl(100); step(); end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule